// File: doc/BRIEF.md
# Converter Start-Up and Overcurrent Recovery Sequencer

This block orders the start of a multi-phase buck converter and its recovery after an overcurrent. It advances only on a one-clock pulse that marks each switching period, so all of its intervals are measured in switching periods. When the supply is good and nothing asks for a stop, the block first leaves the PWM stage floating. It then clamps the low-side switches by forcing the PWM stage low. After that it enables modulation and raises a reference word linearly from zero up to a target. The target comes from a 5-bit voltage-identification code.

An overcurrent during clamp, ramp or run sends the block back to the floating wait. This time the wait lasts a full soft-start length before the clamp and ramp are tried again. If the fault is still there, the same wait-and-retry loop repeats. A supply drop, a disable request or the "off" identification code stops the block at once. The sequence then restarts from the short first wait. The completion flag rises only when the reference has reached its target.

States: `ST_IDLE` (stopped), `ST_WAIT` (floating wait, short or hiccup length), `ST_CLAMP` (forced low), `ST_RAMP` (reference rising), `ST_RUN` (regulating). Transitions: `ST_IDLE`→`ST_WAIT` when enabled. `ST_WAIT`→`ST_CLAMP` when the wait expires. `ST_CLAMP`→`ST_RAMP` when the clamp expires. `ST_RAMP`→`ST_RUN` when the ramp expires. `ST_CLAMP`/`ST_RAMP`/`ST_RUN`→`ST_WAIT` on overcurrent, which selects the hiccup wait length. Any state goes to `ST_IDLE` on a stop condition.

Top module: `vcore_softstart_seq`

## Requirements
- R1: While reset is held, and after reset before enabling, `pwm_mode` is 0 (floating), `ref_word` is 0 and `ss_done` is 0. `pwm_mode` never takes the value 3.
- R2: A code c from 0 to 30 on `vid_code` selects a target of 1100 + 25·(30 − c) in millivolt units. Code 30 gives 1100, code 0 gives 1850.
- R3: Code 31 on `vid_code` stops the sequencer. From the next clock `pwm_mode` is 0, `ref_word` is 0 and `ss_done` is 0, and this holds for as long as the code stays.
- R4: On a normal start, `pwm_mode` stays 0 and `ref_word` stays 0 for exactly 32 ticks.
- R5: After the wait, `pwm_mode` is 1 (forced low) for exactly 150 ticks with `ref_word` at 0. `pwm_mode` never passes straight from 0 to 2, and `ref_word` is 0 whenever `pwm_mode` is not 2.
- R6: In the ramp, `pwm_mode` is 2. After k ramp ticks, `ref_word` equals floor(k·T/1866) for target T, and it rises by at most 1 per clock.
- R7: On the 2048th tick of a normal start, `ss_done` rises and `ref_word` equals the target. `ss_done` is only ever high while `pwm_mode` is 2.
- R8: An overcurrent while `pwm_mode` is 1 or 2 sets `pwm_mode` to 0, `ref_word` to 0 and `ss_done` to 0 on the next clock. The block then waits 2048 ticks, clamps for 150 ticks and ramps for 1866 ticks before `ss_done` rises again.
- R9: A repeated overcurrent during a retry starts another full 2048-tick wait each time.
- R10: An overcurrent during the floating wait is ignored, and the wait length is unchanged.
- R11: A low `supply_ok` or a high `disable_req` sets `pwm_mode` to 0 from the next clock. On release the sequence restarts with the short 32-tick wait.
- R12: In the run state, `ref_word` follows a new identification code one clock after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per switching period |
| supply_ok | input | 1 | Supply above its start threshold |
| disable_req | input | 1 | Request to stop the converter |
| oc_flag | input | 1 | Overcurrent detected |
| vid_code | input | 5 | Voltage-identification code |
| ref_word | output | 11 | Reference level in millivolt units |
| pwm_mode | output | 2 | 0 floating, 1 forced low, 2 modulating |
| ss_done | output | 1 | Soft-start complete |

## Verification
The ramp is driven with a mid-range target and sampled at its first tick, in the middle and one tick before the end. This separates a linear, correctly scaled ramp from one that is early, late or ends off-target. A table of identification codes in run mode covers both ends of the range and neighbouring codes, which exposes wrong step size, sign or offset in the decoding. Overcurrent is applied during run, during the hiccup wait and during a retry. Supply loss, disable and the off code are then applied, and the length of the following wait shows whether the short or the long wait was chosen.

// File: rtl/vss_pkg.sv
package vss_pkg;

    typedef enum logic [1:0] {
        PWM_FLOAT = 2'd0,
        PWM_LOW   = 2'd1,
        PWM_MOD   = 2'd2
    } pwm_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_CLAMP = 3'd2,
        ST_RAMP  = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/vss_vid_decode.sv
module vss_vid_decode #(
    parameter int VID_W   = 5,
    parameter int REF_W   = 11,
    parameter int BASE_MV = 1100,
    parameter int STEP_MV = 25
) (
    input  logic [VID_W-1:0] code,
    output logic [REF_W-1:0] target,
    output logic             is_off
);
    localparam int OFF_CODE = (1 << VID_W) - 1;
    localparam int LOW_CODE = OFF_CODE - 1;

    int level;

    always_comb begin
        is_off = (int'(code) == OFF_CODE);
        level  = is_off ? 0 : BASE_MV + STEP_MV * (LOW_CODE - int'(code));
        target = REF_W'(level);
    end
endmodule

// File: rtl/vss_phase_timer.sv
module vss_phase_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = tick && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/vss_ramp_gen.sv
module vss_ramp_gen #(
    parameter int REF_W    = 11,
    parameter int ACC_W    = 13,
    parameter int RAMP_LEN = 1866
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             load,
    input  logic [REF_W-1:0] target,
    output logic [REF_W-1:0] ref_q
);
    localparam logic [ACC_W:0] LEN_W = (ACC_W + 1)'(RAMP_LEN);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + (ACC_W + 1)'(target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            ref_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
            ref_q <= '0;
        end else if (load) begin
            ref_q <= target;
        end else if (step) begin
            if (sum >= LEN_W) begin
                acc_q <= ACC_W'(sum - LEN_W);
                ref_q <= ref_q + REF_W'(1);
            end else begin
                acc_q <= ACC_W'(sum);
            end
        end
    end
endmodule

// File: rtl/vcore_softstart_seq.sv
module vcore_softstart_seq
    import vss_pkg::*;
#(
    parameter int VID_W       = 5,
    parameter int REF_W       = 11,
    parameter int BASE_MV     = 1100,
    parameter int STEP_MV     = 25,
    parameter int FIRST_WAIT  = 32,
    parameter int LOW_CYC     = 150,
    parameter int DONE_CYC    = 2048,
    parameter int HICCUP_WAIT = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic             supply_ok,
    input  logic             disable_req,
    input  logic             oc_flag,
    input  logic [VID_W-1:0] vid_code,
    output logic [REF_W-1:0] ref_word,
    output logic [1:0]       pwm_mode,
    output logic             ss_done
);
    localparam int RAMP_CYC = DONE_CYC - FIRST_WAIT - LOW_CYC;
    localparam int MAX_LEN  = (HICCUP_WAIT > DONE_CYC) ? HICCUP_WAIT : DONE_CYC;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);
    localparam int ACC_W    = CNT_W + 1;

    seq_state_e       state_q, state_d;
    logic             hiccup_q, hiccup_d;
    logic [REF_W-1:0] target;
    logic             vid_off;
    logic             stop_req;
    logic             oc_trip;
    logic             tmr_tick, tmr_clr, tmr_expire;
    logic [CNT_W-1:0] tmr_limit;
    logic             ramp_clr, ramp_step, ramp_load;
    pwm_mode_e        mode;

    vss_vid_decode #(
        .VID_W  (VID_W),
        .REF_W  (REF_W),
        .BASE_MV(BASE_MV),
        .STEP_MV(STEP_MV)
    ) u_vid (
        .code  (vid_code),
        .target(target),
        .is_off(vid_off)
    );

    vss_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tmr_tick),
        .limit (tmr_limit),
        .expire(tmr_expire)
    );

    vss_ramp_gen #(
        .REF_W   (REF_W),
        .ACC_W   (ACC_W),
        .RAMP_LEN(RAMP_CYC)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ramp_clr),
        .step  (ramp_step),
        .load  (ramp_load),
        .target(target),
        .ref_q (ref_word)
    );

    assign stop_req = !supply_ok || disable_req || vid_off;
    assign oc_trip  = oc_flag && !stop_req &&
                      (state_q inside {ST_CLAMP, ST_RAMP, ST_RUN});

    // Next-state and sequencing controls
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_WAIT;
            ST_WAIT:  if (tmr_expire) state_d = ST_CLAMP;
            ST_CLAMP: if (oc_flag) state_d = ST_WAIT;
                      else if (tmr_expire) state_d = ST_RAMP;
            ST_RAMP:  if (oc_flag) state_d = ST_WAIT;
                      else if (tmr_expire) state_d = ST_RUN;
            ST_RUN:   if (oc_flag) state_d = ST_WAIT;
            default:  state_d = ST_IDLE;
        endcase
        if (stop_req) state_d = ST_IDLE;

        if (state_d == ST_IDLE) hiccup_d = 1'b0;
        else if (oc_trip)       hiccup_d = 1'b1;
        else                    hiccup_d = hiccup_q;

        unique case (state_q)
            ST_WAIT:  tmr_limit = hiccup_q ? CNT_W'(HICCUP_WAIT) : CNT_W'(FIRST_WAIT);
            ST_CLAMP: tmr_limit = CNT_W'(LOW_CYC);
            default:  tmr_limit = CNT_W'(RAMP_CYC);
        endcase

        tmr_tick  = cyc_tick && (state_q inside {ST_WAIT, ST_CLAMP, ST_RAMP});
        tmr_clr   = (state_d != state_q);
        ramp_clr  = !(state_d inside {ST_RAMP, ST_RUN});
        ramp_step = (state_q == ST_RAMP) && cyc_tick && !ramp_clr;
        ramp_load = (state_q == ST_RUN) && (state_d == ST_RUN);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hiccup_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            hiccup_q <= hiccup_d;
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            ST_CLAMP:        mode = PWM_LOW;
            ST_RAMP, ST_RUN: mode = PWM_MOD;
            default:         mode = PWM_FLOAT;
        endcase
        ss_done  = (state_q == ST_RUN);
        pwm_mode = mode;
    end
endmodule

// File: rtl/vss_checker.sv
module vss_checker #(
    parameter int VID_W = 5,
    parameter int REF_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             supply_ok,
    input logic             disable_req,
    input logic             oc_flag,
    input logic [VID_W-1:0] vid_code,
    input logic [REF_W-1:0] ref_word,
    input logic [1:0]       pwm_mode,
    input logic             ss_done
);
    localparam logic [VID_W-1:0] OFF_CODE = '1;

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_mode != 2'd3);

    assert_off_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_code == OFF_CODE) |=> (pwm_mode == 2'd0 && ref_word == '0 && !ss_done));

    assert_no_skip_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwm_mode) == 2'd0) |-> (pwm_mode != 2'd2));

    assert_ref_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode != 2'd2) |-> (ref_word == '0));

    assert_ramp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'd2 && $past(pwm_mode) == 2'd2 && !ss_done)
        |-> (ref_word == $past(ref_word) || ref_word == $past(ref_word) + REF_W'(1)));

    assert_done_modulating_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (pwm_mode == 2'd2));

    assert_oc_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && pwm_mode != 2'd0) |=> (pwm_mode == 2'd0 && !ss_done));

    assert_stop_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || disable_req) |=> (pwm_mode == 2'd0));
endmodule

bind vcore_softstart_seq vss_checker #(
    .VID_W(VID_W),
    .REF_W(REF_W)
) u_vss_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .disable_req(disable_req),
    .oc_flag    (oc_flag),
    .vid_code   (vid_code),
    .ref_word   (ref_word),
    .pwm_mode   (pwm_mode),
    .ss_done    (ss_done)
);

// File: tb/vcore_softstart_seq_test.sv
`timescale 1ns/1ps
module vcore_softstart_seq_test;
    localparam int RAMP_LEN = 1866;
    localparam int NVEC = 7;
    localparam logic [4:0] VEC_CODE [NVEC] = '{5'd30, 5'd0, 5'd29, 5'd15, 5'd16, 5'd1, 5'd10};
    localparam int         VEC_MV   [NVEC] = '{1100, 1850, 1125, 1475, 1450, 1825, 1600};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0;
    logic        supply_ok = 1'b0;
    logic        disable_req = 1'b0;
    logic        oc_flag = 1'b0;
    logic [4:0]  vid_code = 5'd10;
    logic [10:0] ref_word;
    logic [1:0]  pwm_mode;
    logic        ss_done;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    vcore_softstart_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_tick   (cyc_tick),
        .supply_ok  (supply_ok),
        .disable_req(disable_req),
        .oc_flag    (oc_flag),
        .vid_code   (vid_code),
        .ref_word   (ref_word),
        .pwm_mode   (pwm_mode),
        .ss_done    (ss_done)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1;
            @(negedge clk);
            cyc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic oc_pulse();
        oc_flag = 1'b1;
        @(negedge clk);
        oc_flag = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode in reset", int'(pwm_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode idle", int'(pwm_mode), 0);
        chk("R1 ref idle", int'(ref_word), 0);
        chk("R1 done idle", int'(ss_done), 0);

        // normal start, target 1600
        supply_ok = 1'b1;
        @(negedge clk);
        ticks(31);
        chk("R4 float at 31", int'(pwm_mode), 0);
        chk("R4 ref at 31", int'(ref_word), 0);
        ticks(1);
        chk("R4 clamp after 32", int'(pwm_mode), 1);
        ticks(149);
        chk("R5 low at 149", int'(pwm_mode), 1);
        ticks(1);
        chk("R5 modulate after 150", int'(pwm_mode), 2);
        chk("R5 ramp start ref", int'(ref_word), 0);
        ticks(1);
        chk("R6 ramp k=1", int'(ref_word), (1 * 1600) / RAMP_LEN);
        ticks(499);
        chk("R6 ramp k=500", int'(ref_word), (500 * 1600) / RAMP_LEN);
        ticks(1365);
        chk("R6 ramp k=1865", int'(ref_word), (1865 * 1600) / RAMP_LEN);
        chk("R7 not done at 2047", int'(ss_done), 0);
        ticks(1);
        chk("R7 done at 2048", int'(ss_done), 1);
        chk("R7 ref at target", int'(ref_word), 1600);

        // table of codes in run mode
        for (int i = 0; i < NVEC; i++) begin
            vid_code = VEC_CODE[i];
            @(negedge clk);
            chk("R2 R12 decoded level", int'(ref_word), VEC_MV[i]);
        end

        // overcurrent hiccup, with oc during the wait
        oc_pulse();
        chk("R8 float after oc", int'(pwm_mode), 0);
        chk("R8 ref after oc", int'(ref_word), 0);
        chk("R8 done after oc", int'(ss_done), 0);
        ticks(1000);
        oc_pulse();
        @(negedge clk);
        chk("R10 oc in wait ignored", int'(pwm_mode), 0);
        ticks(1047);
        chk("R8 R10 float at 2047", int'(pwm_mode), 0);
        ticks(1);
        chk("R8 R10 clamp after 2048", int'(pwm_mode), 1);
        ticks(150);
        chk("R8 retry modulating", int'(pwm_mode), 2);
        chk("R8 retry not done", int'(ss_done), 0);
        ticks(1866);
        chk("R8 retry done", int'(ss_done), 1);
        chk("R8 retry ref", int'(ref_word), 1600);

        // persistent fault: retry interrupted again
        oc_pulse();
        ticks(2048);
        chk("R9 clamp after wait", int'(pwm_mode), 1);
        ticks(160);
        chk("R9 ramp running", int'(pwm_mode), 2);
        oc_pulse();
        chk("R9 float again", int'(pwm_mode), 0);
        ticks(2047);
        chk("R9 long wait again", int'(pwm_mode), 0);
        ticks(1);
        chk("R9 clamp again", int'(pwm_mode), 1);

        // supply loss restarts with the short wait
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R11 float on supply loss", int'(pwm_mode), 0);
        chk("R11 ref on supply loss", int'(ref_word), 0);
        supply_ok = 1'b1;
        @(negedge clk);
        ticks(31);
        chk("R11 short wait at 31", int'(pwm_mode), 0);
        ticks(1);
        chk("R11 short wait clamp", int'(pwm_mode), 1);

        disable_req = 1'b1;
        @(negedge clk);
        chk("R11 float on disable", int'(pwm_mode), 0);
        ticks(40);
        chk("R11 held by disable", int'(pwm_mode), 0);
        disable_req = 1'b0;
        @(negedge clk);
        ticks(31);
        chk("R11 restart wait", int'(pwm_mode), 0);
        ticks(1);
        chk("R11 restart clamp", int'(pwm_mode), 1);

        // off code
        vid_code = 5'd31;
        @(negedge clk);
        chk("R3 float on off code", int'(pwm_mode), 0);
        chk("R3 ref on off code", int'(ref_word), 0);
        chk("R3 done on off code", int'(ss_done), 0);
        ticks(40);
        chk("R3 held by off code", int'(pwm_mode), 0);
        vid_code = 5'd10;
        @(negedge clk);
        ticks(32);
        chk("R3 restart clamp", int'(pwm_mode), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule